// File: doc/BRIEF.md
# DDR Current-Stress Command Sequencer

This block emits a repeating stream of DDR SDRAM commands for supply-current characterization. Each clock it presents one command (NOP, activate, read, write or precharge) with a bank number, an address and a write-data word. Two loop shapes are available. The first opens, reads and closes a single bank. The second rotates activates across four banks and relies on auto-precharge reads, so it issues no explicit precharge. A speed-grade select picks either the 100 MHz or the 133 MHz slot spacing.

A start pulse launches the selected loop from its first slot. The loop shape, the grade and the seed are captured at that moment. A stop request is held pending and takes effect only at the next loop boundary. Row and column addresses come from a seeded LFSR. Every read also advances a data pattern that flips exactly half of the word's bits.

Top module: `ddr_stress_seq`

## Requirements
- R1: After reset and while idle, cmd_o is NOP and busy_o is low. The command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4. A start_i sampled while idle makes slot 0 appear on the outputs in the next cycle, with busy_o high. A start_i sampled while running has no effect.
- R2: Single-bank loop at the slow grade (four_bank_i=0, fast_grade_i=0) runs for a period of 7 slots: ACT at slot 0, RD at slot 2, PRE at slot 5, NOP at every other slot. All commands use bank 0.
- R3: Single-bank loop at the fast grade (four_bank_i=0, fast_grade_i=1) runs for a period of 9 slots: ACT at slot 0, RD at slot 3, PRE at slot 5, NOP at every other slot. All commands use bank 0.
- R4: Four-bank loop at the slow grade runs for a period of 8 slots: ACT b0, RD b3, ACT b1, RD b0, ACT b2, RD b1, ACT b3, RD b2. In the first pass, slot 1 is a NOP instead of RD b3. Every read therefore follows the activate of its bank by 3 cycles.
- R5: Four-bank loop at the fast grade runs for a period of 10 slots: ACT b0, NOP, ACT b1, RD b0, ACT b2, RD b1, ACT b3, RD b2, NOP, RD b3.
- R6: A stop_i seen while running is remembered. The loop then ends at the next boundary, with a NOP and busy_o low instead of slot 0. In the four-bank slow-grade loop, the boundary instead issues a NOP and then the pending RD b3, both with busy_o high, before the block goes idle. A stop_i while idle, or in the same cycle as an accepted start, is ignored.
- R7: The address generator is a 16-bit right-shifting Galois LFSR with feedback mask 0xB400. It is loaded with seed_i at start, and a zero seed is replaced by 1. Each ACT or RD uses the current value and then advances it. ACT drives the low 13 LFSR bits as the row. RD drives bits 9:2 of the LFSR on addr_o[9:2], zeros on bits 1:0, and on bit 10 the auto-precharge flag, which is 1 in four-bank mode and 0 in single-bank mode. PRE drives an all-zero address.
- R8: On a NOP slot inside a running single-bank loop, addr_o is the bitwise inverse of its previous value. On every other NOP (four-bank, stop, tail or idle), addr_o is unchanged. bank_o never changes on a NOP.
- R9: At reset, wdata_o is 0 and an internal mask holds ones in its low half. Each RD XORs the mask into wdata_o and then rotates the mask left by one bit, so exactly half of the bits change. wdata_o stays constant in all other cycles.
- R10: four_bank_i, fast_grade_i and seed_i are sampled only when a start is accepted. Changing them while running does not alter the loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the selected loop |
| stop_i | input | 1 | Request an end at the next loop boundary |
| four_bank_i | input | 1 | 1 selects the four-bank interleave |
| fast_grade_i | input | 1 | 1 selects the 133 MHz spacing |
| seed_i | input | 16 | LFSR seed, captured at start |
| cmd_o | output | 3 | Command code |
| bank_o | output | 2 | Bank address |
| addr_o | output | 13 | Row, column or precharge address |
| wdata_o | output | 16 | Write-data pattern word |
| busy_o | output | 1 | Outputs belong to a running loop |

## Verification
The stop request and the loop wrap can meet in the same cycle. The bench provokes this by holding stop_i through a whole pass, by pulsing it in the cycle that issues the last slot, and by holding start_i and stop_i together so that a stop and a restart follow each other back to back. A behavioural model built from per-slot pattern strings predicts the NOP at the boundary, the tail of the four-bank slow loop and the restart timing. The bench compares that prediction with every output on every clock, and it also compares the model's LFSR and data mask with the design's outputs.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] v);
    return v[0] ? ((v >> 1) ^ LFSR_TAPS) : (v >> 1);
  endfunction
endpackage

// File: rtl/dss_slot_dec.sv
module dss_slot_dec
  import dss_pkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int BANK_W = 2
) (
  input  logic              four_bank_i,
  input  logic              fast_i,
  input  logic              first_i,
  input  logic [SLOT_W-1:0] slot_i,
  output cmd_e              cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              last_o
);
  localparam logic [SLOT_W-1:0] S1_LAST_SLOW = SLOT_W'(6);
  localparam logic [SLOT_W-1:0] S1_LAST_FAST = SLOT_W'(8);
  localparam logic [SLOT_W-1:0] S4_LAST_SLOW = SLOT_W'(7);
  localparam logic [SLOT_W-1:0] S4_LAST_FAST = SLOT_W'(9);
  localparam logic [SLOT_W-1:0] RD_SLOW      = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] RD_FAST      = SLOT_W'(3);
  localparam logic [SLOT_W-1:0] PRE_SLOT     = SLOT_W'(5);

  always_comb begin
    cmd_o  = CMD_NOP;
    bank_o = '0;
    if (!four_bank_i) begin
      last_o = (slot_i == (fast_i ? S1_LAST_FAST : S1_LAST_SLOW));
      if (slot_i == '0)                              cmd_o = CMD_ACT;
      else if (slot_i == (fast_i ? RD_FAST : RD_SLOW)) cmd_o = CMD_RD;
      else if (slot_i == PRE_SLOT)                   cmd_o = CMD_PRE;
    end else begin
      last_o = (slot_i == (fast_i ? S4_LAST_FAST : S4_LAST_SLOW));
      // even slots 0..6 activate banks 0..3; odd slots 3..7 read the bank opened 3 slots earlier
      if (slot_i <= SLOT_W'(6) && !slot_i[0]) begin
        cmd_o  = CMD_ACT;
        bank_o = BANK_W'(slot_i >> 1);
      end else if (slot_i >= SLOT_W'(3) && slot_i <= SLOT_W'(7) && slot_i[0]) begin
        cmd_o  = CMD_RD;
        bank_o = BANK_W'((slot_i - SLOT_W'(3)) >> 1);
      end else if (slot_i == SLOT_W'(1) && !fast_i && !first_i) begin
        cmd_o  = CMD_RD;
        bank_o = BANK_W'(3);
      end else if (slot_i == SLOT_W'(9) && fast_i) begin
        cmd_o  = CMD_RD;
        bank_o = BANK_W'(3);
      end
    end
  end
endmodule

// File: rtl/dss_lfsr.sv
module dss_lfsr
  import dss_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              adv_i,
  output logic [LFSR_W-1:0] cur_o
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] seed_nz;

  assign seed_nz = (seed_i == '0) ? LFSR_W'(1) : seed_i;
  assign cur_o   = load_i ? seed_nz : state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= LFSR_W'(1);
    else if (adv_i)  state_q <= lfsr_step(cur_o);
    else             state_q <= cur_o;
  end
endmodule

// File: rtl/dss_wpat.sv
module dss_wpat #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] MASK_INIT = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [DATA_W-1:0] data_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      mask_q <= MASK_INIT;
    end else if (step_i) begin
      data_q <= data_q ^ mask_q;
      mask_q <= {mask_q[DATA_W-2:0], mask_q[DATA_W-1]};
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/ddr_stress_seq.sv
module ddr_stress_seq
  import dss_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int SLOT_W = 4,
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              four_bank_i,
  input  logic              fast_grade_i,
  input  logic [15:0]       seed_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              busy_o
);
  localparam int AP_BIT = 10;

  logic              run_q, busy_q, tail_q, first_q, stop_pend_q, fb_q, fast_q;
  logic [SLOT_W-1:0] slot_q;
  cmd_e              cmd_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;

  logic              starting, stop_now, go_tail, issue;
  logic              fb_c, fast_c, first_c;
  logic [SLOT_W-1:0] slot_c;
  cmd_e              dec_cmd, cmd_n;
  logic [BANK_W-1:0] dec_bank;
  logic              dec_last;
  logic [LFSR_W-1:0] lf_cur;
  logic [ADDR_W-1:0] rd_addr, addr_n;

  assign starting = !run_q && start_i;
  assign stop_now = run_q && !tail_q && (slot_q == '0) && (stop_pend_q || stop_i);
  assign go_tail  = stop_now && fb_q && !fast_q && !first_q;
  assign issue    = starting || (run_q && !stop_now);

  assign fb_c    = starting ? four_bank_i  : fb_q;
  assign fast_c  = starting ? fast_grade_i : fast_q;
  assign first_c = starting ? 1'b1 : first_q;
  assign slot_c  = starting ? '0 : slot_q;

  dss_slot_dec #(.SLOT_W(SLOT_W), .BANK_W(BANK_W)) u_dec (
    .four_bank_i(fb_c),
    .fast_i     (fast_c),
    .first_i    (first_c),
    .slot_i     (slot_c),
    .cmd_o      (dec_cmd),
    .bank_o     (dec_bank),
    .last_o     (dec_last)
  );

  assign cmd_n = issue ? dec_cmd : CMD_NOP;

  dss_lfsr u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(starting),
    .seed_i(seed_i),
    .adv_i (issue && (dec_cmd == CMD_ACT || dec_cmd == CMD_RD)),
    .cur_o (lf_cur)
  );

  dss_wpat #(.DATA_W(DATA_W)) u_wpat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(issue && dec_cmd == CMD_RD),
    .data_o(wdata_o)
  );

  always_comb begin
    rd_addr = '0;
    rd_addr[COL_W-1:2] = lf_cur[COL_W-1:2];
    rd_addr[AP_BIT]    = fb_c;
  end

  always_comb begin
    unique case (cmd_n)
      CMD_ACT: addr_n = lf_cur[ADDR_W-1:0];
      CMD_RD:  addr_n = rd_addr;
      CMD_PRE: addr_n = '0;
      default: addr_n = (issue && !fb_c) ? ~addr_q : addr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      busy_q      <= 1'b0;
      tail_q      <= 1'b0;
      first_q     <= 1'b0;
      stop_pend_q <= 1'b0;
      fb_q        <= 1'b0;
      fast_q      <= 1'b0;
      slot_q      <= '0;
      cmd_q       <= CMD_NOP;
      bank_q      <= '0;
      addr_q      <= '0;
    end else begin
      cmd_q  <= cmd_n;
      addr_q <= addr_n;
      if (issue && dec_cmd != CMD_NOP) bank_q <= dec_bank;
      if (starting) begin
        run_q       <= 1'b1;
        busy_q      <= 1'b1;
        fb_q        <= four_bank_i;
        fast_q      <= fast_grade_i;
        first_q     <= 1'b1;
        stop_pend_q <= 1'b0;
        slot_q      <= SLOT_W'(1);
      end else if (run_q) begin
        if (tail_q) begin
          run_q  <= 1'b0;
          tail_q <= 1'b0;
          busy_q <= 1'b1;
          slot_q <= '0;
        end else if (stop_now) begin
          stop_pend_q <= 1'b0;
          if (go_tail) begin
            tail_q <= 1'b1;
            busy_q <= 1'b1;
            slot_q <= SLOT_W'(1);
          end else begin
            run_q  <= 1'b0;
            busy_q <= 1'b0;
          end
        end else begin
          busy_q      <= 1'b1;
          stop_pend_q <= stop_pend_q || stop_i;
          slot_q      <= dec_last ? '0 : slot_q + SLOT_W'(1);
          if (dec_last) first_q <= 1'b0;
        end
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign cmd_o  = cmd_q;
  assign bank_o = bank_q;
  assign addr_o = addr_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16,
  parameter int BANK_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        cmd_o,
  input logic [BANK_W-1:0] bank_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] wdata_o,
  input logic              busy_o
);
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_PRE = 3'd4;

  AST_IDLE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cmd_o == C_NOP); // R1
  AST_RD_AFTER_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == C_RD |-> (($past(cmd_o, 2) == C_ACT && $past(bank_o, 2) == bank_o) ||
                       ($past(cmd_o, 3) == C_ACT && $past(bank_o, 3) == bank_o))); // R4
  AST_PRE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == C_PRE |-> $past(cmd_o, 5) == C_ACT); // R2
  AST_PRE_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == C_PRE |-> addr_o == '0); // R7
  AST_RD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == C_RD |-> addr_o[1:0] == 2'b00); // R7
  AST_NOP_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == C_NOP |-> $stable(bank_o)); // R8
  AST_WDATA_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == C_RD |-> $countones(wdata_o ^ $past(wdata_o)) == DATA_W / 2); // R9
  AST_WDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o != C_RD |-> $stable(wdata_o)); // R9
endmodule

bind ddr_stress_seq dss_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cmd_o  (cmd_o),
  .bank_o (bank_o),
  .addr_o (addr_o),
  .wdata_o(wdata_o),
  .busy_o (busy_o)
);

// File: tb/ddr_stress_seq_bench.sv
module ddr_stress_seq_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, four_bank_i = 1'b0, fast_grade_i = 1'b0;
  logic [15:0] seed_i = 16'h0;
  logic [2:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [12:0] addr_o;
  logic [15:0] wdata_o;
  logic        busy_o;

  always #4 clk = ~clk;

  ddr_stress_seq u_ddr_stress_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .four_bank_i(four_bank_i), .fast_grade_i(fast_grade_i), .seed_i(seed_i),
    .cmd_o(cmd_o), .bank_o(bank_o), .addr_o(addr_o), .wdata_o(wdata_o), .busy_o(busy_o)
  );

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit          m_run, m_busy, m_tail, m_first, m_stop, m_fb, m_fast;
  int          m_slot;
  int          m_cmd, m_bank;
  logic [12:0] m_addr;
  logic [15:0] m_wd, m_mask, m_lf;
  string       m_tag;

  function automatic string pat_cmd(bit fb, bit fast);
    if (!fb) return fast ? "ANNRNPNNN" : "ANRNNPN";
    return fast ? "ANARARARNR" : "ARARARAR";
  endfunction
  function automatic string pat_bank(bit fb, bit fast);
    if (!fb) return fast ? "000000000" : "0000000";
    return fast ? "0010213223" : "03102132";
  endfunction

  task automatic m_issue(input int slot);
    string pc = pat_cmd(m_fb, m_fast);
    string pb = pat_bank(m_fb, m_fast);
    byte c = pc[slot];
    if (m_fb && !m_fast && slot == 1 && m_first) c = "N";
    case (c)
      "A": begin
        m_cmd = 1; m_bank = pb[slot] - "0";
        m_addr = m_lf[12:0];
        m_lf = m_lf[0] ? ((m_lf >> 1) ^ 16'hB400) : (m_lf >> 1);
      end
      "R": begin
        m_cmd = 2; m_bank = pb[slot] - "0";
        m_addr = '0; m_addr[9:2] = m_lf[9:2]; m_addr[10] = m_fb;
        m_lf = m_lf[0] ? ((m_lf >> 1) ^ 16'hB400) : (m_lf >> 1);
        m_wd = m_wd ^ m_mask;
        m_mask = {m_mask[14:0], m_mask[15]};
      end
      "P": begin m_cmd = 4; m_addr = '0; end
      default: begin m_cmd = 0; if (!m_fb) m_addr = ~m_addr; end
    endcase
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_busy = 0; m_tail = 0; m_first = 0; m_stop = 0; m_fb = 0; m_fast = 0;
      m_slot = 0; m_cmd = 0; m_bank = 0; m_addr = '0; m_wd = '0; m_mask = 16'h00FF;
      m_lf = 16'h1; m_tag = "R1";
    end else if (!m_run && start_i) begin
      m_fb = four_bank_i; m_fast = fast_grade_i; m_first = 1; m_stop = 0;
      m_lf = (seed_i == 0) ? 16'h1 : seed_i;
      m_run = 1; m_busy = 1; m_tag = "R1";
      m_issue(0);
      m_slot = 1;
    end else if (m_run) begin
      if (m_tail) begin
        m_issue(1);
        m_tail = 0; m_run = 0; m_busy = 1; m_slot = 0; m_tag = "R6";
      end else if (m_slot == 0 && (m_stop || stop_i)) begin
        m_stop = 0; m_cmd = 0; m_tag = "R6";
        if (m_fb && !m_fast && !m_first) begin m_tail = 1; m_slot = 1; m_busy = 1; end
        else begin m_run = 0; m_busy = 0; end
      end else begin
        m_stop = m_stop || stop_i;
        m_issue(m_slot);
        m_slot++;
        if (m_slot == pat_cmd(m_fb, m_fast).len()) begin m_slot = 0; m_first = 0; end
        if (four_bank_i != m_fb || fast_grade_i != m_fast) m_tag = "R10";
        else if (!m_fb) m_tag = m_fast ? "R3" : "R2";
        else m_tag = m_fast ? "R5" : "R4";
      end
    end else begin
      m_busy = 0; m_cmd = 0; m_tag = "R1";
    end
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      chk(m_tag, "cmd", cmd_o, m_cmd);
      chk((m_cmd == 0) ? "R8" : m_tag, "bank", bank_o, m_bank);
      chk((m_cmd == 0) ? "R8" : "R7", "addr", addr_o, m_addr);
      chk("R9", "wdata", wdata_o, m_wd);
      chk(m_busy ? "R1" : "R6", "busy", busy_o, m_busy);
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy_o) break;
    end
  endtask

  task automatic run_loop(input bit fb, input bit fast, input logic [15:0] seed,
                          input int run_cyc, input bit flip);
    @(negedge clk);
    four_bank_i = fb; fast_grade_i = fast; seed_i = seed; start_i = 1;
    @(negedge clk);
    start_i = 0;
    for (int i = 0; i < run_cyc; i++) begin
      @(negedge clk);
      if (flip && i == 3) begin  // R10: inputs change mid-run
        four_bank_i = ~fb; fast_grade_i = ~fast; seed_i = ~seed;
      end
    end
    stop_i = 1;
    @(negedge clk);
    stop_i = 0;
    wait_idle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 / R6: stop while idle is ignored
    repeat (2) @(negedge clk);
    stop_i = 1;
    @(negedge clk);
    stop_i = 0;
    repeat (2) @(negedge clk);
    run_loop(0, 0, 16'hACE1, 17, 0); // R2
    run_loop(0, 1, 16'h0000, 20, 1); // R3, R10, zero seed
    run_loop(1, 0, 16'h1234, 19, 1); // R4, R6 tail
    run_loop(1, 1, 16'hBEEF, 10, 0); // R5
    // R6: stop pulsed on the cycle issuing the last slot (single slow, period 7)
    @(negedge clk);
    four_bank_i = 0; fast_grade_i = 0; seed_i = 16'h5A5A; start_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (5) @(negedge clk);
    stop_i = 1;
    @(negedge clk);
    stop_i = 0;
    wait_idle();
    // R1 / R6: start and stop together while idle, then both held for back-to-back restarts
    @(negedge clk);
    four_bank_i = 1; fast_grade_i = 0; seed_i = 16'h0F0F; start_i = 1; stop_i = 1;
    @(negedge clk);
    stop_i = 0;
    repeat (12) @(negedge clk); // start still high: ignored while running
    stop_i = 1;
    repeat (30) @(negedge clk);
    start_i = 0; stop_i = 0;
    wait_idle();
    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule